// File: doc/BRIEF.md
# Four-Channel PWM Pulse Generator

This block is the counting core of a four-output pulse-width modulator. A single period counter runs from a prescaled tick and is compared against four per-channel duty words. Each duty word is 16 bits wide: the low 15 bits are the compare level and the top bit flips the polarity of that channel. The counter either climbs from zero to its top and wraps, which gives edge-aligned pulses, or climbs to the top and then descends back to zero, which gives pulses centred on the counter minimum.

A sequencer outside the block writes new duty words and, when it wants to, a new counter top. These writes go into a pending stage. The running period never sees them; they move into the active stage only when a period ends, so a period can never mix old and new settings. The block raises a one-cycle pulse at every period end. It accepts a start request while idle, and it accepts a stop request that takes effect when the current period finishes. All four outputs sit low while the block is idle.

Top module: `pwm4_core`

## Requirements
- R1: After reset, `idle_o` is 1, `pwm_o` is 0 and `period_end_o` is 0.
- R2: The 3-bit `div_i` code k makes the counter step once every 2^k clock cycles (k from 0 to 7). In up mode, one period therefore lasts (top+1)·2^k clock cycles.
- R3: Up mode (`center_i`=0): the counter runs 0..top and then wraps. A channel with polarity 0 is high while the counter is below its compare level. Compare 0 keeps the channel always low, and a compare above top keeps it always high.
- R4: Bit 15 of a duty word set to 1 inverts that channel's output for the whole period.
- R5: Center mode (`center_i`=1, top≥1): the counter runs 0,1..top,top−1..1. The period is 2·top ticks, and a polarity-0 channel with compare c, where 1≤c≤top, is high for 2·c−1 ticks.
- R6: `period_end_o` is high for exactly one clock cycle at the end of each period. It coincides with the first cycle in which the counter is back at 0.
- R7: Duty words written through `ld_i` (channel n at bits 16n+15:16n of `ld_duty_i`) do not affect the current period. They apply from the next period on.
- R8: A top written through `ld_top_en_i` leaves the current period length unchanged and sets the length of the following periods.
- R9: A pulse on `stop_i` while running lets the current period finish. Then `idle_o` rises in the same cycle as that period's `period_end_o`, and all outputs go low with no further period pulses.
- R10: `start_i` while running and `stop_i` while idle have no effect.
- R11: `start_i` while idle copies the pending duties and top into the active stage, and the counter begins at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse (ignored while running) |
| stop_i | input | 1 | Stop-at-period-end pulse |
| div_i | input | 3 | Prescaler code, divide by 2^code |
| center_i | input | 1 | 0 = edge-aligned, 1 = center-aligned counting |
| ld_i | input | 1 | Write all four pending duty words |
| ld_duty_i | input | 64 | Four duty words: bit 15 polarity, bits 14:0 compare |
| ld_top_en_i | input | 1 | Write pending counter top |
| ld_top_i | input | 15 | Pending counter top value |
| pwm_o | output | 4 | PWM outputs |
| period_end_o | output | 1 | One-cycle pulse at each period end |
| idle_o | output | 1 | High while no pulses are generated |

## Verification
The hardest case to reach from the ports is a write to the pending stage that lands in the middle of a running period. Its effect must be confined to the period after it. The stimulus first lines up on a `period_end_o` pulse, which marks counter value 0. It then writes new duties or a new top a few cycles into that period and compares the high-time or length of that period and the next one. The stop case is driven the same way: the stop request is placed just after a period boundary, so the whole remaining period must run before `idle_o` rises.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_t;
endpackage

// File: rtl/pwm4_rst_sync.sv
module pwm4_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PSC_W = (1 << DIV_W) - 1;

  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W:0]   mask_full;
  logic [PSC_W-1:0] mask;

  always_comb begin
    mask_full = ((PSC_W+1)'(1) << div_i) - (PSC_W+1)'(1);
    mask      = mask_full[PSC_W-1:0];
    tick_o    = run_i && ((psc_q & mask) == mask);
    psc_d     = run_i ? psc_q + PSC_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/pwm4_counter.sv
module pwm4_counter
  import pwm4_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             center_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  dir_t             dir_q, dir_d;
  logic             wrap;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (tick_i) begin
      if (!center_i) begin
        dir_d = DIR_UP;
        if (cnt_q >= top_i) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= top_i) begin
          if (cnt_q <= CNT_W'(1)) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
            dir_d = DIR_DOWN;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d = '0;
          wrap  = 1'b1;
          dir_d = DIR_UP;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= top_i));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel #(
  parameter int CNT_W = 15,
  localparam int DUTY_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] pend_q, pend_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic              below;

  always_comb begin
    pend_d = wr_i ? wr_data_i : pend_q;
    act_d  = load_i ? pend_q : act_q;
    below  = cnt_i < act_q[CNT_W-1:0];
    pwm_o  = run_i & (below ^ act_q[CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/pwm4_core.sv
module pwm4_core #(
  parameter int CH_N  = 4,
  parameter int CNT_W = 15,
  parameter int DIV_W = 3,
  localparam int DUTY_W = CNT_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [DIV_W-1:0]       div_i,
  input  logic                   center_i,
  input  logic                   ld_i,
  input  logic [CH_N*DUTY_W-1:0] ld_duty_i,
  input  logic                   ld_top_en_i,
  input  logic [CNT_W-1:0]       ld_top_i,
  output logic [CH_N-1:0]        pwm_o,
  output logic                   period_end_o,
  output logic                   idle_o
);
  logic             rst_n_i;
  logic             run_q, run_d;
  logic             stop_pend_q, stop_pend_d;
  logic             pe_q;
  logic [CNT_W-1:0] pend_top_q, pend_top_d;
  logic [CNT_W-1:0] act_top_q, act_top_d;
  logic             tick, wrap, start_go, stopping, load_act;
  logic [CNT_W-1:0] cnt;

  pwm4_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pwm4_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .run_i  (run_q),
    .div_i  (div_i),
    .tick_o (tick)
  );

  pwm4_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .tick_i   (tick),
    .clr_i    (start_go),
    .center_i (center_i),
    .run_i    (run_q),
    .top_i    (act_top_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  always_comb begin
    start_go    = start_i && !run_q;
    stopping    = wrap && stop_pend_q;
    load_act    = start_go || wrap;
    run_d       = run_q;
    stop_pend_d = stop_pend_q;
    if (start_go) begin
      run_d       = 1'b1;
      stop_pend_d = 1'b0;
    end else if (stopping) begin
      run_d       = 1'b0;
      stop_pend_d = 1'b0;
    end else if (stop_i && run_q) begin
      stop_pend_d = 1'b1;
    end
    pend_top_d = ld_top_en_i ? ld_top_i : pend_top_q;
    act_top_d  = load_act ? pend_top_q : act_top_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      pe_q        <= 1'b0;
      pend_top_q  <= '1;
      act_top_q   <= '1;
    end else begin
      run_q       <= run_d;
      stop_pend_q <= stop_pend_d;
      pe_q        <= wrap;
      pend_top_q  <= pend_top_d;
      act_top_q   <= act_top_d;
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    pwm4_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .wr_i      (ld_i),
      .wr_data_i (ld_duty_i[g*DUTY_W +: DUTY_W]),
      .load_i    (load_act),
      .run_i     (run_q),
      .cnt_i     (cnt),
      .pwm_o     (pwm_o[g])
    );
  end

  assign period_end_o = pe_q;
  assign idle_o       = !run_q;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    idle_o |-> (pwm_o == '0));

  // R9
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(idle_o) |-> period_end_o);

  // R6
  pe_running_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    period_end_o |-> !$past(idle_o));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!idle_o && start_i && !stop_pend_q) |=> !idle_o);
endmodule

// File: tb/sim_pwm4_core.sv
`timescale 1ns/1ps
module sim_pwm4_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, stop_i, center_i, ld_i, ld_top_en_i;
  logic [2:0]  div_i;
  logic [63:0] ld_duty_i;
  logic [14:0] ld_top_i;
  logic [3:0]  pwm_o;
  logic        period_end_o, idle_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm4_core u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .div_i(div_i), .center_i(center_i), .ld_i(ld_i), .ld_duty_i(ld_duty_i),
    .ld_top_en_i(ld_top_en_i), .ld_top_i(ld_top_i), .pwm_o(pwm_o),
    .period_end_o(period_end_o), .idle_o(idle_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dw(input bit pol, input int cmp);
    return {pol, 15'(cmp)};
  endfunction

  task automatic load_all(input logic [15:0] d0, d1, d2, d3, input int top);
    ld_duty_i   = {d3, d2, d1, d0};
    ld_i        = 1'b1;
    ld_top_i    = 15'(top);
    ld_top_en_i = 1'b1;
    @(negedge clk);
    ld_i        = 1'b0;
    ld_top_en_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // counts highs per channel over n samples, starting at the current negedge
  task automatic count_high(input int n, output int h[4]);
    for (int c = 0; c < 4; c++) h[c] = 0;
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < 4; c++) h[c] += int'(pwm_o[c]);
      @(negedge clk);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_end_o && n < 2000);
  endtask

  task automatic stop_wait();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    for (int i = 0; i < 2000 && !idle_o; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 idle", int'(idle_o), 1);
    check("R1 pwm", int'(pwm_o), 0);
    check("R1 period_end", int'(period_end_o), 0);
  endtask

  task automatic t_up();
    int h[4];
    int p;
    div_i = 3'd0; center_i = 1'b0;
    load_all(dw(0, 3), dw(1, 3), dw(0, 0), dw(0, 20), 9);
    do_start();
    check("R11 running after start", int'(idle_o), 0);
    check("R11 ch0 high at count 0", int'(pwm_o[0]), 1);
    count_high(10, h);
    check("R3 ch0 high cycles", h[0], 3);
    check("R4 ch1 inverted high cycles", h[1], 7);
    check("R3 compare zero low", h[2], 0);
    check("R3 compare above top high", h[3], 10);
    check("R6 pulse at first wrap", int'(period_end_o), 1);
    measure(p);
    check("R2 up period div1", p, 10);
    @(negedge clk);
    check("R6 single-cycle pulse", int'(period_end_o), 0);
    stop_wait();
  endtask

  task automatic t_div();
    int h[4];
    int p;
    div_i = 3'd2; center_i = 1'b0;
    load_all(dw(0, 3), dw(0, 0), dw(0, 0), dw(0, 0), 9);
    do_start();
    count_high(40, h);
    check("R2 ch0 high cycles div4", h[0], 12);
    measure(p);
    check("R2 period div4", p, 40);
    stop_wait();
    div_i = 3'd7;
    load_all(dw(0, 1), dw(0, 0), dw(0, 0), dw(0, 0), 1);
    do_start();
    measure(p);
    check("R2 period div128", p, 256);
    stop_wait();
  endtask

  task automatic t_center();
    int h[4];
    int p;
    div_i = 3'd0; center_i = 1'b1;
    load_all(dw(0, 2), dw(0, 5), dw(0, 6), dw(0, 0), 5);
    do_start();
    count_high(10, h);
    check("R5 ch0 high ticks", h[0], 3);
    check("R5 ch1 high ticks", h[1], 9);
    check("R5 ch2 above top", h[2], 10);
    check("R5 ch3 zero", h[3], 0);
    measure(p);
    check("R5 center period", p, 10);
    stop_wait();
    center_i = 1'b0;
  endtask

  task automatic t_dbuf();
    int h[4];
    int p;
    div_i = 3'd0; center_i = 1'b0;
    load_all(dw(0, 2), dw(1, 2), dw(0, 0), dw(0, 0), 9);
    do_start();
    measure(p);
    for (int c = 0; c < 4; c++) h[c] = 0;
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < 4; c++) h[c] += int'(pwm_o[c]);
      if (i == 3) begin
        ld_duty_i = {dw(0, 0), dw(0, 0), dw(0, 6), dw(0, 6)};
        ld_i = 1'b1;
      end else begin
        ld_i = 1'b0;
      end
      @(negedge clk);
    end
    ld_i = 1'b0;
    check("R7 old duty kept in current period", h[0], 2);
    check("R7 old inverted duty kept", h[1], 8);
    count_high(10, h);
    check("R7 new duty next period", h[0], 6);
    check("R7 new polarity next period", h[1], 6);
    stop_wait();
  endtask

  task automatic t_top();
    int p;
    div_i = 3'd0; center_i = 1'b0;
    load_all(dw(0, 1), dw(0, 0), dw(0, 0), dw(0, 0), 9);
    do_start();
    measure(p);
    p = 0;
    do begin
      if (p == 2) begin
        ld_top_i = 15'd4;
        ld_top_en_i = 1'b1;
      end else begin
        ld_top_en_i = 1'b0;
      end
      @(negedge clk);
      p++;
    end while (!period_end_o && p < 2000);
    ld_top_en_i = 1'b0;
    check("R8 current period unchanged", p, 10);
    measure(p);
    check("R8 new top next period", p, 5);
    stop_wait();
  endtask

  task automatic t_stop();
    int p;
    int bad = 0;
    div_i = 3'd0; center_i = 1'b0;
    load_all(dw(1, 0), dw(0, 0), dw(0, 0), dw(0, 0), 9);
    do_start();
    measure(p);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    for (int k = 1; k < 10; k++) begin
      if (idle_o || !pwm_o[0]) bad++;
      @(negedge clk);
    end
    check("R9 runs to period end", bad, 0);
    check("R9 idle at period end", int'(idle_o), 1);
    check("R9 pulse with stop", int'(period_end_o), 1);
    check("R9 outputs low when idle", int'(pwm_o), 0);
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (period_end_o || !idle_o) bad++;
    end
    check("R9 no pulses after stop", bad, 0);
  endtask

  task automatic t_ignore();
    int p;
    div_i = 3'd0; center_i = 1'b0;
    load_all(dw(0, 4), dw(0, 0), dw(0, 0), dw(0, 0), 9);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R10 stop while idle stays idle", int'(idle_o), 1);
    do_start();
    measure(p);
    measure(p);
    check("R10 stale stop not kept", int'(idle_o), 0);
    p = 0;
    do begin
      start_i = (p == 3);
      @(negedge clk);
      p++;
    end while (!period_end_o && p < 2000);
    start_i = 1'b0;
    check("R10 start while running ignored", p, 10);
    stop_wait();
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 0; stop_i = 0; center_i = 0; ld_i = 0; ld_top_en_i = 0;
    div_i = 0; ld_duty_i = '0; ld_top_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_up();
    t_div();
    t_center();
    t_dbuf();
    t_top();
    t_stop();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule